// File: doc/BRIEF.md
# Multiplexed-Address DRAM Pin Emulator

This block behaves like a small x4 asynchronous DRAM as seen from its pins. A fast system clock samples the active-low row strobe, column strobe, write enable and output enable. Strobe edges are found by comparing each registered sample with the one before it. A row address is taken when the row strobe falls, and a column address is taken when the column strobe falls, both from one shared address bus. The array is a parameterized register file holding 2^(ROW_W+COL_W) words of DQ_W bits. The shared bidirectional data bus is split into separate `dq_in`, `dq_out` and `dq_oe` pins, so that a pad ring or a bench can rebuild the tri-state bus.

What the block does in a cycle depends on the order of the edges. When write enable is already low as the column strobe falls, the cycle is an early write: the bus is never driven. When write enable falls later, the cycle is a late write, and it takes effect only if output enable is high at that moment. While the row strobe stays low, the column strobe may be pulsed again to reach other columns of the same row. Read data stays on the bus after the column strobe rises, in extended data-out fashion. Refresh cycles are recognised and counted, and they leave the array untouched. A row-strobe-only cycle is one kind; the other kind has the column strobe low before the row strobe falls, and it also covers hidden refresh.

The pins have no handshake, because they model a strobe-timed memory and not a stream. Any change on a strobe pin is acted on two clock edges later: one edge registers the new sample and the next edge applies its effect. A host must therefore hold each pin level, and the address and data that go with it, for at least three clocks.

Top module: `dram_emu`

## Requirements
- R1: After reset, `dq_oe` is 0 and both refresh counters read 0.
- R2: With write enable high and output enable low, a fall of the row strobe followed by a fall of the column strobe drives the word at {row, column} onto `dq_out` with `dq_oe` = 1. The row bits fill the upper ROW_W bits of the array index.
- R3: If write enable is low when the column strobe falls (early write), `dq_in` is stored at {row, column}, and `dq_oe` stays 0 for that column cycle even with output enable low.
- R4: If write enable falls while the column strobe is already low, output enable is high and no write has happened in that column cycle (late write), the `dq_in` value present at that fall is stored.
- R5: A late write attempted while output enable is low stores nothing, and the bus keeps driving the addressed word.
- R6: While the row strobe stays low, each new fall of the column strobe takes a new column within the latched row (page mode).
- R7: After a read, the data stays driven after the column strobe rises. It is released only when the next column fall starts another cycle, or when both strobes are high.
- R8: Output enable high forces `dq_oe` to 0. Taking it low again during a held read drives the data again.
- R9: If the column strobe is low when the row strobe falls, `rfsh_cbr_cnt` increments by one. Column cycles and write-enable edges during that row-strobe-low period do not access the array.
- R10: A row-strobe-low period that ends with no column fall increments `rfsh_ras_cnt` by one.
- R11: Hidden refresh: when the column strobe is held low after a read and the row strobe goes high and then low again, `rfsh_cbr_cnt` increments and the read data stays driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Data from the bus |
| dq_out | output | DQ_W | Data toward the bus |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| rfsh_ras_cnt | output | CNT_W | Row-strobe-only refresh count |
| rfsh_cbr_cnt | output | CNT_W | Column-before-row refresh count |

## Verification
The bench targets the order of write enable against the column strobe, which decides every write.

- A design that treated an early write as a read would drive the bus during that cycle.
- A design that ignored output enable on a late write would corrupt the cell that read-modify-write is meant to protect.
- The bench holds data through column-strobe rise, output-enable toggles and hidden refresh. A design that released the bus too early, or that held it past the end of the cycle, shows a wrong `dq_oe`.
- The bench performs writes during column-before-row refresh and then reads the cells back. A design that let a refresh cycle touch the array would leave altered cells.
- Random mixes of reads and the three write kinds are compared against a model array kept in the bench.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;

  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
    logic oe;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ras: 1'b1, cas: 1'b1, we: 1'b1, oe: 1'b1};

  function automatic int unsigned max_w(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_emu_sampler.sv
module dram_emu_sampler
  import dram_emu_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DQ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           pins,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   din,
  output strobe_t           now,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DQ_W-1:0]   din_q,
  output logic              ras_fall,
  output logic              ras_rise,
  output logic              cas_fall,
  output logic              we_fall
);

  strobe_t prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now    <= STROBE_IDLE;
      prev   <= STROBE_IDLE;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      now    <= pins;
      prev   <= now;
      addr_q <= addr;
      din_q  <= din;
    end
  end

  assign ras_fall = prev.ras & ~now.ras;
  assign ras_rise = ~prev.ras & now.ras;
  assign cas_fall = prev.cas & ~now.cas;
  assign we_fall  = prev.we & ~now.we;

endmodule

// File: rtl/dram_emu_ctrl.sv
module dram_emu_ctrl
  import dram_emu_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 8,
  localparam int IDX_W = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           now,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              ras_fall,
  input  logic              ras_rise,
  input  logic              cas_fall,
  input  logic              we_fall,
  output logic              wr_en,
  output logic              late_wr,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              early_cyc,
  output logic              cbr_act,
  output logic [CNT_W-1:0]  cnt_ras,
  output logic [CNT_W-1:0]  cnt_cbr
);

  logic             active;
  logic             cas_seen;
  logic             wrote;
  logic [ROW_W-1:0] row_r;
  logic [COL_W-1:0] col_r;
  logic             early_wr;

  assign early_wr = active & cas_fall & ~now.we;
  assign late_wr  = active & ~now.cas & ~cas_fall & we_fall & ~wrote
                    & ~early_cyc & now.oe;
  assign wr_en    = early_wr | late_wr;
  assign wr_idx   = cas_fall ? {row_r, addr_q[COL_W-1:0]} : {row_r, col_r};
  assign rd_idx   = {row_r, col_r};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cas_seen  <= 1'b0;
      wrote     <= 1'b0;
      early_cyc <= 1'b0;
      rd_valid  <= 1'b0;
      cbr_act   <= 1'b0;
      row_r     <= '0;
      col_r     <= '0;
      cnt_ras   <= '0;
      cnt_cbr   <= '0;
    end else begin
      // row strobe edges
      if (ras_fall) begin
        if (!now.cas) begin
          cbr_act <= 1'b1;
          cnt_cbr <= cnt_cbr + 1'b1;
        end else begin
          active   <= 1'b1;
          cas_seen <= 1'b0;
          row_r    <= addr_q[ROW_W-1:0];
        end
      end
      if (ras_rise) begin
        if (active && !cas_seen) cnt_ras <= cnt_ras + 1'b1;
        active  <= 1'b0;
        cbr_act <= 1'b0;
      end
      // column cycle start
      if (active && cas_fall) begin
        col_r     <= addr_q[COL_W-1:0];
        cas_seen  <= 1'b1;
        early_cyc <= ~now.we;
        wrote     <= ~now.we;
        rd_valid  <= now.we;
      end
      // late write commits and ends the read
      if (late_wr) begin
        wrote    <= 1'b1;
        rd_valid <= 1'b0;
      end
      // both strobes high ends any held data
      if (now.ras && now.cas) begin
        rd_valid  <= 1'b0;
        early_cyc <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dram_emu_array.sv
module dram_emu_array #(
  parameter int IDX_W = 6,
  parameter int DQ_W  = 4,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DQ_W-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DQ_W-1:0]  rd_data
);

  logic [DQ_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_data;
  end

  assign rd_data = cells[rd_idx];

endmodule

// File: rtl/dram_emu.sv
module dram_emu
  import dram_emu_pkg::*;
#(
  parameter int ROW_W = 3,
  parameter int COL_W = 3,
  parameter int DQ_W  = 4,
  parameter int CNT_W = 8,
  localparam int ADDR_W = max_w(ROW_W, COL_W),
  localparam int IDX_W  = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic [CNT_W-1:0]  rfsh_ras_cnt,
  output logic [CNT_W-1:0]  rfsh_cbr_cnt
);

  strobe_t           pins;
  strobe_t           smp_now;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   din_q;
  logic              ras_fall, ras_rise, cas_fall, we_fall;
  logic              wr_en, late_wr, rd_valid, early_cyc, cbr_act;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DQ_W-1:0]   rd_data;

  assign pins = '{ras: ras_n, cas: cas_n, we: we_n, oe: oe_n};

  dram_emu_sampler #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .pins(pins), .addr(addr), .din(dq_in),
    .now(smp_now), .addr_q(addr_q), .din_q(din_q),
    .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall),
    .we_fall(we_fall)
  );

  dram_emu_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
                  .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .now(smp_now), .addr_q(addr_q),
    .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall),
    .we_fall(we_fall), .wr_en(wr_en), .late_wr(late_wr),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .rd_valid(rd_valid),
    .early_cyc(early_cyc), .cbr_act(cbr_act),
    .cnt_ras(rfsh_ras_cnt), .cnt_cbr(rfsh_cbr_cnt)
  );

  dram_emu_array #(.IDX_W(IDX_W), .DQ_W(DQ_W)) u_arr (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(din_q),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  assign dq_oe  = rd_valid & ~smp_now.oe;
  assign dq_out = rd_valid ? rd_data : '0;

endmodule

// File: rtl/dram_emu_chk.sv
module dram_emu_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oe_n,
  input logic             dq_oe,
  input logic             oe_q,
  input logic             wr_en,
  input logic             late_wr,
  input logic             early_cyc,
  input logic             cbr_act,
  input logic [CNT_W-1:0] cnt_ras,
  input logic [CNT_W-1:0] cnt_cbr
);

  // R8: drive only after output enable was seen low
  a_r8_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !$past(oe_n));

  // R5: a late write never commits while output enable is low
  a_r5_late_needs_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    late_wr |-> oe_q);

  // R3: an early-write column cycle never drives the bus
  a_r3_early_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    early_cyc |-> !dq_oe);

  // R9: no array write during a refresh row cycle
  a_r9_cbr_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_act |-> !wr_en);

  // R9: refresh count moves by one step only
  a_r9_cbr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_cbr != $past(cnt_cbr)) |-> (cnt_cbr == $past(cnt_cbr) + 1'b1));

  // R10: row-only refresh count moves by one step only
  a_r10_ras_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ras != $past(cnt_ras)) |-> (cnt_ras == $past(cnt_ras) + 1'b1));

endmodule

bind dram_emu dram_emu_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dq_oe(dq_oe),
  .oe_q(smp_now.oe), .wr_en(wr_en), .late_wr(late_wr),
  .early_cyc(early_cyc), .cbr_act(cbr_act),
  .cnt_ras(rfsh_ras_cnt), .cnt_cbr(rfsh_cbr_cnt)
);

// File: tb/dram_emu_bench.sv
`timescale 1ns/100ps
module dram_emu_bench;

  localparam int ROW_W = 3;
  localparam int COL_W = 3;
  localparam int DQ_W  = 4;
  localparam int CNT_W = 8;
  localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int NCELL = 1 << (ROW_W + COL_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0]    addr = '0;
  logic [DQ_W-1:0]  dq_in = '0;
  logic [DQ_W-1:0]  dq_out;
  logic             dq_oe;
  logic [CNT_W-1:0] rfsh_ras_cnt, rfsh_cbr_cnt;

  logic [DQ_W-1:0] model [NCELL];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dram_emu #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .CNT_W(CNT_W)) u_dram_emu (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .rfsh_ras_cnt(rfsh_ras_cnt), .rfsh_cbr_cnt(rfsh_cbr_cnt)
  );

  function automatic int idx(int r, int c);
    return (r << COL_W) | c;
  endfunction

  task automatic step();
    repeat (3) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic row_open(int r);
    addr = AW'(r); ras_n = 1'b0; step();
  endtask

  task automatic row_close();
    cas_n = 1'b1; step(); ras_n = 1'b1; step(); we_n = 1'b1; oe_n = 1'b1; step();
  endtask

  task automatic early_write(int r, int c, logic [DQ_W-1:0] d);
    row_open(r);
    addr = AW'(c); dq_in = d; we_n = 1'b0; oe_n = 1'b0; step();
    cas_n = 1'b0; step();
    chk("R3 early write bus idle", dq_oe, 0);
    model[idx(r, c)] = d;
    row_close();
  endtask

  task automatic read_chk(string req, int r, int c);
    row_open(r);
    addr = AW'(c); we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; step();
    chk({req, " read oe"}, dq_oe, 1);
    chk({req, " read data"}, dq_out, model[idx(r, c)]);
    row_close();
  endtask

  task automatic late_write(int r, int c, logic [DQ_W-1:0] d, bit oe_low);
    row_open(r);
    addr = AW'(c); we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; step();
    dq_in = d;
    if (!oe_low) begin oe_n = 1'b1; step(); end
    we_n = 1'b0; step();
    if (oe_low) begin
      chk("R5 suppressed still drives", dq_oe, 1);
      chk("R5 suppressed keeps data", dq_out, model[idx(r, c)]);
    end else begin
      model[idx(r, c)] = d;
    end
    row_close();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1 reset oe", dq_oe, 0);
    chk("R1 reset ras cnt", rfsh_ras_cnt, 0);
    chk("R1 reset cbr cnt", rfsh_cbr_cnt, 0);

    // fill the array with page-mode early writes (R6)
    for (int r = 0; r < (1 << ROW_W); r++) begin
      row_open(r);
      for (int c = 0; c < (1 << COL_W); c++) begin
        addr = AW'(c); dq_in = DQ_W'(r * 3 + c * 5); we_n = 1'b0; step();
        cas_n = 1'b0; step();
        model[idx(r, c)] = DQ_W'(r * 3 + c * 5);
        cas_n = 1'b1; step();
      end
      row_close();
    end
    chk("R10 no refresh count after access rows", rfsh_ras_cnt, 0);
    read_chk("R2", 2, 5);
    read_chk("R6", 7, 0);

    // EDO hold, OE gating, release
    row_open(3);
    addr = 3'd6; we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; step();
    cas_n = 1'b1; step();
    chk("R7 held after cas rise", dq_oe, 1);
    chk("R7 held data", dq_out, model[idx(3, 6)]);
    oe_n = 1'b1; step();
    chk("R8 oe high releases", dq_oe, 0);
    oe_n = 1'b0; step();
    chk("R8 oe low redrives", dq_oe, 1);
    ras_n = 1'b1; step();
    chk("R7 both strobes high release", dq_oe, 0);
    oe_n = 1'b1; step();

    // page mode reads
    row_open(4);
    we_n = 1'b1; oe_n = 1'b0;
    for (int c = 1; c < 6; c += 2) begin
      addr = AW'(c); cas_n = 1'b0; step();
      chk("R6 page column data", dq_out, model[idx(4, c)]);
      cas_n = 1'b1; step();
    end
    row_close();

    late_write(1, 1, 4'hA, 0);
    read_chk("R4", 1, 1);
    late_write(1, 2, ~model[idx(1, 2)], 1);
    read_chk("R5", 1, 2);

    // column-before-row refresh with attempted writes
    addr = 3'd0; dq_in = ~model[idx(0, 0)]; we_n = 1'b0; cas_n = 1'b0; step();
    ras_n = 1'b0; step();
    chk("R9 cbr count", rfsh_cbr_cnt, 1);
    cas_n = 1'b1; step(); cas_n = 1'b0; step();
    we_n = 1'b1; step(); we_n = 1'b0; step();
    chk("R9 no drive in refresh", dq_oe, 0);
    row_close();
    read_chk("R9", 0, 0);

    // row-only refresh
    row_open(5); ras_n = 1'b1; step();
    chk("R10 ras-only count", rfsh_ras_cnt, 1);

    // hidden refresh
    row_open(6);
    addr = 3'd3; we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; step();
    ras_n = 1'b1; step();
    chk("R11 held across ras high", dq_oe, 1);
    ras_n = 1'b0; step();
    chk("R11 hidden cbr count", rfsh_cbr_cnt, 2);
    chk("R11 data kept", dq_out, model[idx(6, 3)]);
    row_close();
    chk("R10 hidden refresh not ras-only", rfsh_ras_cnt, 1);

    // constrained random mix
    void'($urandom(32'd1357));
    for (int i = 0; i < 150; i++) begin
      int op = $urandom_range(0, 3);
      int r = $urandom_range(0, (1 << ROW_W) - 1);
      int c = $urandom_range(0, (1 << COL_W) - 1);
      logic [DQ_W-1:0] d = DQ_W'($urandom);
      case (op)
        0: read_chk("R2 random", r, c);
        1: early_write(r, c, d);
        2: late_write(r, c, d, 0);
        default: late_write(r, c, d, 1);
      endcase
    end
    for (int k = 0; k < NCELL; k += 9) read_chk("R3 final sweep", k >> COL_W, k % (1 << COL_W));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule